// File: doc/BRIEF.md
# Clock Synthesizer Reconfiguration Sequencer

This block supervises a reconfigurable clock synthesizer and the engine that rewrites its divider settings. Once the device has finished configuring, the sequencer watches a board-level pin that reports which of two reference clocks feeds the synthesizer. It compares the divider set that pin calls for with the set currently loaded. When the two differ, it presents the wanted set, issues a one-cycle reconfiguration request and waits for the engine's busy line to rise and then fall. Whether or not a rewrite took place, it then holds the synthesizer in reset for a fixed number of cycles before declaring the clocks ready.

The pin is asynchronous and may bounce. It is resynchronised and must hold a new level for a programmable run of cycles before it is acted upon. A later accepted change restarts the whole check, rewrite and reset sequence. A pin change that arrives while a sequence is running is acted on once that sequence ends. If the engine fails to finish within a bounded window, the sequencer flags an error and returns to idle without resetting the synthesizer. It stays there until the pin calls for a different set.

Top module: `pll_reseq_ctrl`

## Requirements
- R1: While rst_n is low, reconf_req, synth_rst, ready and seq_err are 0 and div_sel equals BOOT_SET. BOOT_SET is the set the synthesizer holds at power-up.
- R2: clk_src_sel passes through SYNC_STAGES flip-flops. A new level is accepted only after it has been sampled unchanged for STABLE_CYC consecutive cycles. A shorter pulse causes no request, no reset and no change of div_sel.
- R3: No sequence starts while cfg_done is 0.
- R4: Pin level 0 selects divider set A and level 1 selects set B. div_sel shows the selected set with the same encoding. When the accepted set differs from the loaded set, reconf_req is high for exactly one cycle.
- R5: After the request, the sequencer waits until eng_busy has been seen high and is then seen low. Only then does the requested set count as loaded.
- R6: After a completed rewrite, synth_rst is high for exactly RST_CYC consecutive cycles.
- R7: When the accepted set equals the loaded set, no request is issued and the RST_CYC-cycle reset follows directly.
- R8: ready is 1 only while idle after a sequence has completed without error. It is 0 throughout every sequence.
- R9: If the engine has not finished within TIMEOUT_CYC cycles of the request, seq_err is set, the sequencer returns to idle without asserting synth_rst, and the loaded set is left unchanged.
- R10: A pin change accepted during a sequence starts a new sequence once the current one ends. Starting a new sequence clears seq_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Device configuration finished; enables sequencing |
| clk_src_sel | input | 1 | Asynchronous reference-clock indicator pin (0 = set A, 1 = set B) |
| eng_busy | input | 1 | Reconfiguration engine busy |
| div_sel | output | 1 | Divider set to load (0 = A, 1 = B) |
| reconf_req | output | 1 | One-cycle reconfiguration request |
| synth_rst | output | 1 | Synthesizer reset |
| ready | output | 1 | Clocks settled, no sequence running |
| seq_err | output | 1 | Engine timeout seen on the last attempt |

## Verification
The bench builds the block with STABLE_CYC = 4, RST_CYC = 6, TIMEOUT_CYC = 20 and the default two-stage synchronizer. These values make a glitch shorter than the filter run cheap to produce. They also keep an engine that never drops busy within reach of the timeout in a few dozen cycles. Short hold and timeout windows let one run cover boot with and without a rewrite, a pin change during an engine wait, and recovery after a timeout.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/pll_reseq_cnt.sv
module pll_reseq_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)     q_d = '0;
    else if (en) q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (clr || en) q <= q_d;
  end

endmodule

// File: rtl/pll_reseq_sync.sv
module pll_reseq_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STABLE_CYC  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic sel_val,
  output logic sel_ok
);

  localparam int unsigned RW = pll_reseq_pkg::cnt_width(STABLE_CYC);
  localparam logic [RW-1:0] RUN_MAX = RW'(STABLE_CYC);

  logic [SYNC_STAGES-1:0] chain;
  logic                   s_sync;
  logic                   cand, cand_d;
  logic [RW-1:0]          run, run_d;
  logic                   run_en;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign s_sync = chain[SYNC_STAGES-1];

  always_comb begin
    cand_d = cand;
    run_d  = run;
    run_en = 1'b0;
    if (s_sync != cand) begin
      cand_d = s_sync;
      run_d  = RW'(1);
      run_en = 1'b1;
    end else if (run != RUN_MAX) begin
      run_d  = run + 1'b1;
      run_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand <= 1'b0;
      run  <= '0;
    end else if (run_en) begin
      cand <= cand_d;
      run  <= run_d;
    end
  end

  assign sel_val = cand;
  assign sel_ok  = (run == RUN_MAX);

  // R2: an accepted level never changes without first losing acceptance
  p_accept_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && $past(sel_ok)) |-> $stable(sel_val));

endmodule

// File: rtl/pll_reseq_fsm.sv
module pll_reseq_fsm
  import pll_reseq_pkg::*;
#(
  parameter int unsigned RST_CYC     = 16,
  parameter int unsigned TIMEOUT_CYC = 1024,
  parameter bit          BOOT_SET    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_done,
  input  logic sel_val,
  input  logic sel_ok,
  input  logic eng_busy,
  output logic div_sel,
  output logic reconf_req,
  output logic synth_rst,
  output logic ready,
  output logic seq_err
);

  localparam int unsigned CMAX = (RST_CYC > TIMEOUT_CYC) ? RST_CYC : TIMEOUT_CYC;
  localparam int unsigned CW   = cnt_width(CMAX);
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_CYC - 1);

  seq_state_e    state, state_d;
  logic          loaded, loaded_d;
  logic          applied, applied_d;
  logic          started, started_d;
  logic          err, err_d;
  logic          seen, seen_d;
  logic          cnt_clr, cnt_en;
  logic [CW-1:0] cnt;
  logic          start_ok;

  pll_reseq_cnt #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .q     (cnt)
  );

  assign start_ok = cfg_done && sel_ok && (!started || (sel_val != applied));

  always_comb begin
    state_d   = state;
    loaded_d  = loaded;
    applied_d = applied;
    started_d = started;
    err_d     = err;
    seen_d    = seen;
    cnt_clr   = 1'b0;
    cnt_en    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_ok) begin
          applied_d = sel_val;
          started_d = 1'b1;
          err_d     = 1'b0;
          seen_d    = 1'b0;
          cnt_clr   = 1'b1;
          state_d   = (sel_val != loaded) ? ST_REQ : ST_HOLD;
        end
      end
      ST_REQ: begin
        seen_d  = 1'b0;
        cnt_clr = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (seen && !eng_busy) begin
          loaded_d = applied;
          cnt_clr  = 1'b1;
          state_d  = ST_HOLD;
        end else if (cnt == TO_LAST) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_en = 1'b1;
          seen_d = seen | eng_busy;
        end
      end
      ST_HOLD: begin
        if (cnt == RST_LAST) state_d = ST_IDLE;
        else                 cnt_en  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      loaded  <= BOOT_SET;
      applied <= BOOT_SET;
      started <= 1'b0;
      err     <= 1'b0;
      seen    <= 1'b0;
    end else begin
      state   <= state_d;
      loaded  <= loaded_d;
      applied <= applied_d;
      started <= started_d;
      err     <= err_d;
      seen    <= seen_d;
    end
  end

  assign div_sel    = applied;
  assign reconf_req = (state == ST_REQ);
  assign synth_rst  = (state == ST_HOLD);
  assign ready      = (state == ST_IDLE) && started && !err;
  assign seq_err    = err;

  // R3: nothing starts before configuration has finished
  p_cfg_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !cfg_done) |=> (state == ST_IDLE));

  // R4: the request lasts one cycle and leads into the engine wait
  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req |=> (!reconf_req && state == ST_WAIT));

  // R5: leaving the wait for the reset step requires busy to be low
  p_done_on_idle_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && state_d == ST_HOLD) |-> !eng_busy);

  // R6: the reset step is not cut short
  p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (synth_rst && cnt != RST_LAST) |=> synth_rst);

  // R8: ready never overlaps a sequence
  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!synth_rst && !reconf_req));

  // R9: the engine wait is bounded
  p_wait_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> (cnt < CW'(TIMEOUT_CYC)));

endmodule

// File: rtl/pll_reseq_ctrl.sv
module pll_reseq_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STABLE_CYC  = 8,
  parameter int unsigned RST_CYC     = 16,
  parameter int unsigned TIMEOUT_CYC = 1024,
  parameter bit          BOOT_SET    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_done,
  input  logic clk_src_sel,
  input  logic eng_busy,
  output logic div_sel,
  output logic reconf_req,
  output logic synth_rst,
  output logic ready,
  output logic seq_err
);

  logic sel_val;
  logic sel_ok;

  pll_reseq_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .STABLE_CYC  (STABLE_CYC)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (clk_src_sel),
    .sel_val   (sel_val),
    .sel_ok    (sel_ok)
  );

  pll_reseq_fsm #(
    .RST_CYC     (RST_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .BOOT_SET    (BOOT_SET)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_done   (cfg_done),
    .sel_val    (sel_val),
    .sel_ok     (sel_ok),
    .eng_busy   (eng_busy),
    .div_sel    (div_sel),
    .reconf_req (reconf_req),
    .synth_rst  (synth_rst),
    .ready      (ready),
    .seq_err    (seq_err)
  );

  // R1: a held reset keeps every control output quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!reconf_req && !synth_rst && !ready && !seq_err));

endmodule

// File: tb/pll_reseq_ctrl_tb.sv
module pll_reseq_ctrl_tb;

  localparam int PERIOD  = 10;
  localparam int STB     = 4;
  localparam int RSTC    = 6;
  localparam int TOC     = 20;
  localparam int ENG_LEN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_done = 1'b0;
  logic clk_src_sel = 1'b0;
  logic eng_busy = 1'b0;
  logic div_sel, reconf_req, synth_rst, ready, seq_err;
  bit   eng_hang = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  int req_count = 0;
  int rst_count = 0;
  bit done_flag = 1'b0;

  // reference state
  int m1 = 0, m2 = 0, cand = 0, run = 0;
  int st = 0;       // 0 idle, 1 request, 2 wait, 3 hold
  int cnt = 0, seen = 0, loaded = 0, applied = 0, started = 0, err = 0;

  always #(PERIOD/2) clk = ~clk;

  pll_reseq_ctrl #(
    .SYNC_STAGES (2),
    .STABLE_CYC  (STB),
    .RST_CYC     (RSTC),
    .TIMEOUT_CYC (TOC),
    .BOOT_SET    (1'b0)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_done    (cfg_done),
    .clk_src_sel (clk_src_sel),
    .eng_busy    (eng_busy),
    .div_sel     (div_sel),
    .reconf_req  (reconf_req),
    .synth_rst   (synth_rst),
    .ready       (ready),
    .seq_err     (seq_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // engine stand-in: busy rises two cycles after the request, lasts ENG_LEN
  int pend = 0, blen = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      eng_busy <= 1'b0; pend = 0; blen = 0;
    end else if (reconf_req) begin
      pend = 2;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin eng_busy <= 1'b1; blen = ENG_LEN; end
    end else if (blen > 0 && !eng_hang) begin
      blen--;
      if (blen == 0) eng_busy <= 1'b0;
    end
  end

  // behavioural reference, advanced on every rising edge and compared after it
  always @(posedge clk) begin
    int ok_old, cand_old, s_old;
    if (!rst_n) begin
      m1 = 0; m2 = 0; cand = 0; run = 0;
      st = 0; cnt = 0; seen = 0; loaded = 0; applied = 0; started = 0; err = 0;
    end else begin
      ok_old = (run == STB); cand_old = cand; s_old = m2;
      case (st)
        0: if (cfg_done && ok_old && (!started || cand_old != applied)) begin
             applied = cand_old; started = 1; err = 0; seen = 0; cnt = 0;
             st = (cand_old != loaded) ? 1 : 3;
           end
        1: begin st = 2; cnt = 0; seen = 0; end
        2: if (seen && !eng_busy) begin loaded = applied; st = 3; cnt = 0; end
           else if (cnt == TOC - 1) begin err = 1; st = 0; end
           else begin cnt++; if (eng_busy) seen = 1; end
        default: if (cnt == RSTC - 1) st = 0; else cnt++;
      endcase
      if (s_old != cand) begin cand = s_old; run = 1; end
      else if (run < STB) run++;
      m2 = m1; m1 = clk_src_sel;
    end
    #2;
    if (reconf_req) req_count++;
    if (synth_rst)  rst_count++;
    if (!done_flag) begin
      vectors++;
      if (reconf_req !== (st == 1)) begin
        miscompares++;
        $display("FAIL R4 reconf_req: actual %0d expected %0d at %0t", reconf_req, st == 1, $time);
      end
      if (synth_rst !== (st == 3)) begin
        miscompares++;
        $display("FAIL R6 synth_rst: actual %0d expected %0d at %0t", synth_rst, st == 3, $time);
      end
      if (ready !== (st == 0 && started == 1 && err == 0)) begin
        miscompares++;
        $display("FAIL R8 ready: actual %0d expected %0d at %0t", ready,
                 st == 0 && started == 1 && err == 0, $time);
      end
      if (seq_err !== err[0]) begin
        miscompares++;
        $display("FAIL R9 seq_err: actual %0d expected %0d at %0t", seq_err, err, $time);
      end
      if (div_sel !== applied[0]) begin
        miscompares++;
        $display("FAIL R2 div_sel: actual %0d expected %0d at %0t", div_sel, applied, $time);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_seq_end();
    int g;
    g = 0;
    while (ready && g < 60) begin @(negedge clk); g++; end
    g = 0;
    while (!ready && g < 200) begin @(negedge clk); g++; end
  endtask

  initial begin
    #(PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int r0, k0;
    // R1: reset state
    cycles(3);
    check(!reconf_req && !synth_rst && !ready && !seq_err && div_sel == 1'b0,
          "R1 reset outputs", {reconf_req, synth_rst, ready, seq_err, div_sel}, 0);
    rst_n = 1'b1;
    // R3: pin stable but configuration not finished
    cycles(12);
    check(!ready && !synth_rst && req_count == 0, "R3 held before cfg_done", rst_count, 0);
    // R7: boot with matching set: reset only
    cfg_done = 1'b1;
    wait_seq_end();
    check(req_count == 0, "R7 no request at matching boot", req_count, 0);
    check(rst_count == RSTC, "R6 reset length", rst_count, RSTC);
    check(ready == 1'b1, "R8 ready after boot", ready, 1);
    // R2: glitch shorter than the filter run
    clk_src_sel = 1'b1; cycles(STB - 2); clk_src_sel = 1'b0;
    cycles(15);
    check(req_count == 0 && ready && div_sel == 1'b0, "R2 glitch ignored", req_count, 0);
    // R4/R5: switch to set B
    r0 = rst_count;
    clk_src_sel = 1'b1;
    wait_seq_end();
    check(req_count == 1, "R4 one request cycle", req_count, 1);
    check(div_sel == 1'b1, "R5 set B loaded", div_sel, 1);
    check(rst_count - r0 == RSTC, "R6 reset after rewrite", rst_count - r0, RSTC);
    // R10: change pin while engine is busy
    clk_src_sel = 1'b0;
    k0 = 0;
    while (!reconf_req && k0 < 60) begin @(negedge clk); k0++; end
    clk_src_sel = 1'b1;
    wait_seq_end();
    cycles(20);
    check(req_count == 3, "R10 follow-up sequence", req_count, 3);
    check(div_sel == 1'b1 && ready, "R10 final set B", div_sel, 1);
    // R9: engine never finishes
    eng_hang = 1'b1;
    r0 = rst_count;
    clk_src_sel = 1'b0;
    k0 = 0;
    while (!seq_err && k0 < 100) begin @(negedge clk); k0++; end
    check(seq_err == 1'b1, "R9 timeout flag", seq_err, 1);
    cycles(3);
    check(rst_count == r0 && !ready, "R9 no reset on timeout", rst_count - r0, 0);
    eng_hang = 1'b0;
    cycles(10);
    // R7/R10: back to loaded set B: reset only, error cleared
    k0 = req_count;
    clk_src_sel = 1'b1;
    wait_seq_end();
    check(req_count == k0, "R7 no request for loaded set", req_count - k0, 0);
    check(!seq_err && ready, "R10 error cleared", seq_err, 0);
    // R4: boot with set B requested
    rst_n = 1'b0; cfg_done = 1'b0;
    cycles(3);
    check(div_sel == 1'b0 && !ready, "R1 reset again", div_sel, 0);
    rst_n = 1'b1; cfg_done = 1'b1;
    k0 = req_count;
    wait_seq_end();
    check(req_count == k0 + 1 && div_sel == 1'b1, "R4 rewrite at boot", req_count - k0, 1);
    cycles(5);
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule